// File: doc/BRIEF.md
# Vectored Multi-Bank Interrupt Controller

This block collects up to 96 interrupt sources into banks of 32 and drives a single interrupt request line towards a processor. Each bank has a pending view, an enable register and a mask register. A source takes part in arbitration only when it is pending, its enable bit is 1 and its mask bit is 0. A vector register reports the lowest-numbered participating source. The value is shifted left by two, so software shifts it right by two to recover the index.

Source 0 is an external line that is captured into a sticky flag. The capture follows a programmable trigger: low level, high level, falling edge or rising edge. The flag stays set until software writes 1 to bit 0 of the first pending bank. Every other source is level-sensitive and follows its input with no acknowledge. The vector reads 0 both when nothing is active and when source 0 wins, so software reads bit 0 of the first pending bank to tell the two apart. A protection bit restricts register writes to privileged accesses. A parameter selects an alternate address layout for the enable and mask banks.

The source 0 capture is a two-state machine. In `EXT_IDLE` the flag is clear. The transition *capture* goes to `EXT_HELD` on a clock edge where the selected trigger condition is true. In `EXT_HELD` the flag is set. The transition *acknowledge* returns to `EXT_IDLE` on an accepted write with bit 0 set to the first pending bank. In every other case the machine stays in `EXT_HELD`. If a level trigger is still true after an acknowledge, the next edge takes *capture* again.

Top module: `irqc_vector_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is low, provided source 0 is held high so that the reset trigger mode (low level) does not capture it.
- R2: Source n appears in pending bank n/32 at bit n%32. The pending banks sit at offset 0x10 + 4*bank. For sources other than 0 the pending bit equals the current input level, and writing ones to a pending bank has no effect on those bits.
- R3: A source is active when it is pending, its enable bit is 1 and its mask bit is 0. `irq_out` is high exactly when at least one source is active. Enable banks sit at 0x40 + 4*bank and mask banks at 0x50 + 4*bank.
- R4: The register at offset 0x00 reads the index of the lowest-numbered active source shifted left by two, and reads 0 when no source is active.
- R5: When source 0 is the lowest active source, offset 0x00 reads 0 while `irq_out` is high and bit 0 of offset 0x10 reads 1.
- R6: Bits [1:0] of offset 0x0C select the capture trigger for source 0: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. The captured flag stays set until a write to offset 0x10 with bit 0 set. A write with bit 0 clear leaves the flag set. A level trigger that is still true recaptures on the following cycle.
- R7: In the default layout, offset 0x20 + 4*bank reads that bank's active bits (pending AND enable AND NOT mask). This view is read-only.
- R8: Bit 0 of offset 0x08 enables protection. While it is 1, writes with `bus_priv` low are ignored and writes with `bus_priv` high are accepted.
- R9: A read returns its data on `bus_rdata` with `bus_rvalid` high one cycle after `bus_rd`. Unmapped offsets read 0.
- R10: With `ALT_MAP` = 1, the enable banks move to 0x20 + 4*bank and the mask banks to 0x30 + 4*bank. The default enable and mask offsets then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| src_in | input | 96 | Interrupt source inputs; bit 0 is the external line |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench uses the ambiguous vector value 0 with source 0 captured and `irq_out` high. A design that encodes the index without the shift, or gives priority to the highest index, reads a wrong vector. Each of the four trigger modes is exercised. This includes an acknowledge while a high level persists, which must recapture, and an acknowledge write with bit 0 clear, which must not clear the flag. Writes of all ones to a bank of level sources must leave it unchanged. Unprivileged writes under protection must leave the enable bank intact. A second instance with the alternate layout confirms that the enable and mask banks move, and that the default read-only view at 0x20 ignores writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    typedef enum logic {
        EXT_IDLE = 1'b0,
        EXT_HELD = 1'b1
    } ext_state_e;

    localparam int BANK_W      = 32;
    localparam int OFF_VEC     = 'h00;
    localparam int OFF_PROT    = 'h08;
    localparam int OFF_EXT     = 'h0C;
    localparam int OFF_PEND    = 'h10;
    localparam int OFF_VIEW    = 'h20;
    localparam int OFF_EN_STD  = 'h40;
    localparam int OFF_MSK_STD = 'h50;
    localparam int OFF_EN_ALT  = 'h20;
    localparam int OFF_MSK_ALT = 'h30;

endpackage

// File: rtl/irqc_ext_line.sv
module irqc_ext_line
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_in,
    input  trig_e mode,
    input  logic  ack,
    output logic  pend
);

    ext_state_e state_q, state_d;
    logic       line_q;
    logic       hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_in;
    end

    always_comb begin
        unique case (mode)
            TRIG_LOW:  hit = ~line_in;
            TRIG_HIGH: hit = line_in;
            TRIG_FALL: hit = ~line_in & line_q;
            TRIG_RISE: hit = line_in & ~line_q;
            default:   hit = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_IDLE: if (hit) state_d = EXT_HELD;
            EXT_HELD: if (ack) state_d = EXT_IDLE;
            default:  state_d = EXT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == EXT_HELD);
    end

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N  = 96,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter bit ALT_MAP   = 1'b0,
    parameter int AW        = 8,
    localparam int FLAT     = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    input  logic              priv,
    input  logic [FLAT-1:0]   pend_flat,
    input  logic [FLAT-1:0]   view_flat,
    input  logic [31:0]       vec_word,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic [FLAT-1:0]   en_flat,
    output logic [FLAT-1:0]   msk_flat,
    output logic              prot_on,
    output trig_e             ext_mode,
    output logic              ext_ack
);

    localparam int EN_BASE  = ALT_MAP ? OFF_EN_ALT  : OFF_EN_STD;
    localparam int MSK_BASE = ALT_MAP ? OFF_MSK_ALT : OFF_MSK_STD;

    logic        wr_ok;
    logic        prot_q;
    trig_e       mode_q;
    logic [31:0] rd_next;

    assign wr_ok   = wr_en & (~prot_q | priv);
    assign ext_ack = wr_ok & (addr == AW'(OFF_PEND)) & wdata[0];
    assign prot_on  = prot_q;
    assign ext_mode = mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            mode_q <= TRIG_LOW;
        end else if (wr_ok) begin
            if (addr == AW'(OFF_PROT)) prot_q <= wdata[0];
            if (addr == AW'(OFF_EXT))  mode_q <= trig_e'(wdata[1:0]);
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [AW-1:0] A_EN  = AW'(EN_BASE + 4 * b);
        localparam logic [AW-1:0] A_MSK = AW'(MSK_BASE + 4 * b);
        logic [BANK_W-1:0] en_q, msk_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q  <= '0;
                msk_q <= '0;
            end else if (wr_ok) begin
                if (addr == A_EN)  en_q  <= wdata;
                if (addr == A_MSK) msk_q <= wdata;
            end
        end

        assign en_flat[b*BANK_W +: BANK_W]  = en_q;
        assign msk_flat[b*BANK_W +: BANK_W] = msk_q;
    end

    always_comb begin
        rd_next = '0;
        if (addr == AW'(OFF_VEC))  rd_next = vec_word;
        if (addr == AW'(OFF_PROT)) rd_next = {31'd0, prot_q};
        if (addr == AW'(OFF_EXT))  rd_next = {30'd0, mode_q};
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == AW'(OFF_PEND + 4 * b)) rd_next = pend_flat[b*BANK_W +: BANK_W];
            if (!ALT_MAP && addr == AW'(OFF_VIEW + 4 * b))
                rd_next = view_flat[b*BANK_W +: BANK_W];
            if (addr == AW'(EN_BASE + 4 * b))  rd_next = en_flat[b*BANK_W +: BANK_W];
            if (addr == AW'(MSK_BASE + 4 * b)) rd_next = msk_flat[b*BANK_W +: BANK_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_next;
        end
    end

endmodule

// File: rtl/irqc_vector_ctrl.sv
module irqc_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter bit ALT_MAP = 1'b0,
    parameter int AW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_priv,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               irq_out
);

    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int FLAT      = NUM_BANKS * BANK_W;
    localparam int IW        = $clog2(FLAT);

    logic [FLAT-1:0] pend_flat, en_flat, msk_flat, active;
    logic            ext_pend, ext_ack, prot_on, found;
    trig_e           ext_mode;
    logic [IW-1:0]   win_idx;
    logic [31:0]     vec_word;

    irqc_ext_line u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (src_in[0]),
        .mode    (ext_mode),
        .ack     (ext_ack),
        .pend    (ext_pend)
    );

    always_comb begin
        pend_flat = '0;
        pend_flat[NUM_SRC-1:1] = src_in[NUM_SRC-1:1];
        pend_flat[0] = ext_pend;
    end

    assign active = pend_flat & en_flat & ~msk_flat;

    irqc_prio_enc #(.N(FLAT)) u_prio (
        .req   (active),
        .found (found),
        .idx   (win_idx)
    );

    assign vec_word = found ? (32'(win_idx) << 2) : 32'd0;
    assign irq_out  = found;

    irqc_regfile #(
        .NUM_BANKS (NUM_BANKS),
        .ALT_MAP   (ALT_MAP),
        .AW        (AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .priv      (bus_priv),
        .pend_flat (pend_flat),
        .view_flat (active),
        .vec_word  (vec_word),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid),
        .en_flat   (en_flat),
        .msk_flat  (msk_flat),
        .prot_on   (prot_on),
        .ext_mode  (ext_mode),
        .ext_ack   (ext_ack)
    );

endmodule

// File: rtl/irqc_vector_ctrl_chk.sv
module irqc_vector_ctrl_chk #(
    parameter int NUM_SRC = 96,
    parameter int AW      = 8,
    parameter int FLAT    = 96
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_priv,
    input logic [AW-1:0]      bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NUM_SRC-1:0] src_in,
    input logic               irq_out,
    input logic               ext_pend,
    input logic               prot_on,
    input logic [FLAT-1:0]    en_flat,
    input logic [31:0]        vec_word
);

    // R4
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_word[1:0] == 2'b00);

    // R4
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_word[31:2] < 30'(NUM_SRC));

    // R3
    idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> vec_word == 32'd0);

    // R3
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (ext_pend || (|src_in[NUM_SRC-1:1])));

    // R6
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_pend && !(bus_wr && (!prot_on || bus_priv) &&
                       bus_addr == AW'('h10) && bus_wdata[0])) |=> ext_pend);

    // R8
    prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && bus_wr && !bus_priv) |=> $stable(en_flat));

endmodule

bind irqc_vector_ctrl irqc_vector_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .AW      (AW),
    .FLAT    (FLAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_in    (src_in),
    .irq_out   (irq_out),
    .ext_pend  (ext_pend),
    .prot_on   (prot_on),
    .en_flat   (en_flat),
    .vec_word  (vec_word)
);

// File: tb/irqc_vector_ctrl_tb.sv
module irqc_vector_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0, bus_priv = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [NSRC-1:0] src_in = '0;
    logic [31:0]     rdata, rdata_alt;
    logic            rvalid, rvalid_alt, irq, irq_alt;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        bit          alt;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_vector_ctrl #(.NUM_SRC(NSRC), .ALT_MAP(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .src_in(src_in), .bus_rdata(rdata), .bus_rvalid(rvalid), .irq_out(irq)
    );

    irqc_vector_ctrl #(.NUM_SRC(NSRC), .ALT_MAP(1'b1)) u_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .src_in(src_in), .bus_rdata(rdata_alt), .bus_rvalid(rvalid_alt), .irq_out(irq_alt)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input bit alt,
                      input string tag);
        exp_t it;
        @(negedge clk);
        it.exp = exp; it.alt = alt; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Scoreboard monitor: pops one expected item per returned read
    always @(negedge clk) begin
        if (rvalid) begin
            if (sb.size() == 0) begin
                chk(32'd1, 32'd0, "R9 unexpected rvalid");
            end else begin
                exp_t it;
                it = sb.pop_front();
                chk(it.alt ? rdata_alt : rdata, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        src_in[0] = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk({31'd0, irq}, 32'd0, "R1 irq after reset");
        chk({31'd0, rvalid}, 32'd0, "R9 rvalid idle");
        rd(8'h40, 32'd0, 0, "R1 enable0");
        rd(8'h50, 32'd0, 0, "R1 mask0");
        rd(8'h08, 32'd0, 0, "R1 prot");
        rd(8'h0C, 32'd0, 0, "R1 ext mode");
        rd(8'h00, 32'd0, 0, "R1 vector");
        rd(8'h10, 32'd0, 0, "R1 pending0");

        // R2 level sources and bank mapping
        wr(8'h0C, 32'd3);
        src_in[37] = 1'b1; src_in[70] = 1'b1;
        tick();
        rd(8'h14, 32'h20, 0, "R2 src37 bank1 bit5");
        rd(8'h18, 32'h40, 0, "R2 src70 bank2 bit6");
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, 32'h20, 0, "R2 write ones ignored on level");

        // R3 gating
        chk({31'd0, irq}, 32'd0, "R3 no enables");
        wr(8'h44, 32'h20);
        chk({31'd0, irq}, 32'd1, "R3 enabled");
        rd(8'h00, 32'd148, 0, "R4 vector src37");
        wr(8'h54, 32'h20);
        chk({31'd0, irq}, 32'd0, "R3 masked");
        rd(8'h00, 32'd0, 0, "R4 vector none");
        wr(8'h54, 32'h0);

        // R4 lowest index wins
        wr(8'h48, 32'h40);
        rd(8'h00, 32'd148, 0, "R4 lowest of 37/70");
        src_in[37] = 1'b0;
        tick();
        rd(8'h00, 32'd280, 0, "R4 vector src70");

        // R7 gated view
        rd(8'h28, 32'h40, 0, "R7 view bank2");
        rd(8'h24, 32'h0, 0, "R7 view bank1");

        // R5/R6 rising edge on source 0
        wr(8'h40, 32'h1);
        src_in[0] = 1'b0; tick(); tick();
        rd(8'h10, 32'd0, 0, "R6 rise no edge yet");
        src_in[0] = 1'b1; tick(); tick();
        chk({31'd0, irq}, 32'd1, "R5 irq with src0");
        rd(8'h00, 32'd0, 0, "R5 vector zero for src0");
        rd(8'h10, 32'd1, 0, "R5 pending0 bit0");
        src_in[0] = 1'b0; tick(); tick();
        rd(8'h10, 32'd1, 0, "R6 held after line drop");
        wr(8'h10, 32'h0);
        rd(8'h10, 32'd1, 0, "R6 zero write keeps flag");
        wr(8'h10, 32'h1); tick();
        rd(8'h10, 32'd0, 0, "R6 ack clears");
        rd(8'h00, 32'd280, 0, "R4 vector after ack");

        // R6 falling edge
        wr(8'h0C, 32'd2);
        src_in[0] = 1'b1; tick(); tick();
        rd(8'h10, 32'd0, 0, "R6 fall no edge on rise");
        src_in[0] = 1'b0; tick(); tick();
        rd(8'h10, 32'd1, 0, "R6 fall captured");
        wr(8'h10, 32'h1); tick();
        rd(8'h10, 32'd0, 0, "R6 fall ack");

        // R6 high level with recapture
        wr(8'h0C, 32'd1); tick();
        rd(8'h10, 32'd0, 0, "R6 high idle");
        src_in[0] = 1'b1; tick(); tick();
        rd(8'h10, 32'd1, 0, "R6 high captured");
        wr(8'h10, 32'h1); tick();
        rd(8'h10, 32'd1, 0, "R6 high recapture");
        src_in[0] = 1'b0;
        wr(8'h10, 32'h1); tick();
        rd(8'h10, 32'd0, 0, "R6 high ack");

        // R6 low level
        wr(8'h0C, 32'd0); tick(); tick();
        rd(8'h10, 32'd1, 0, "R6 low captured");
        src_in[0] = 1'b1;
        wr(8'h10, 32'h1); tick();
        rd(8'h10, 32'd0, 0, "R6 low ack");

        // R9 unmapped
        rd(8'h7C, 32'd0, 0, "R9 unmapped");

        // R8 protection
        wr(8'h08, 32'h1);
        rd(8'h08, 32'h1, 0, "R8 prot set");
        wr(8'h44, 32'hFFFF);
        rd(8'h44, 32'h20, 0, "R8 unprivileged write ignored");
        bus_priv = 1'b1;
        wr(8'h44, 32'h0);
        rd(8'h44, 32'h0, 0, "R8 privileged write accepted");
        wr(8'h08, 32'h0);
        bus_priv = 1'b0;

        // R10 alternate layout and R7 read-only view
        wr(8'h20, 32'h5);
        rd(8'h20, 32'h5, 1, "R10 alt enable0");
        rd(8'h40, 32'h1, 0, "R7 view write ignored, enable0 kept");
        rd(8'h40, 32'h0, 1, "R10 alt std enable unmapped");
        wr(8'h30, 32'h4);
        rd(8'h30, 32'h4, 1, "R10 alt mask0");

        wait (sb.size() == 0);
        tick(); tick();
        finish_run();
    end

endmodule